// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block carries a stream of words from one clock domain to another. A producer on the write clock pushes words and a consumer on the read clock takes them. The two clocks may be fully unrelated. Word width and depth are parameters, and the depth is a power of two. The write and read pointers cross between the domains as Gray codes through multi-flop synchronisers. As a result, a flag that stops the local side updates at once, and a flag that releases the local side updates a few cycles late. Each port has a strobe built from four qualifiers: an active-low select, a direction bit, an enable and a side-channel select. A transfer happens only when all four agree and the port's flag permits it.

A static mode input chooses how the read side behaves. In standard mode, `r_valid` means "memory not empty". Each qualified read copies the oldest word into the `r_data` register. In fall-through mode, the oldest word is preloaded into `r_data` without any request, and `r_valid` then means "output word present". A qualified read consumes the word shown and fetches the next one. Each side has a threshold flag: almost-full on the write clock and almost-empty on the read clock. Both compare a fill level against an offset chosen by a two-bit select. The select is captured during reset.

Top module: `dcf_fifo`

## Requirements
- R1: A write happens on a rising `wclk` edge only if `w_cs_n`=0, `w_dir`=1, `w_en`=1, `w_mbx`=0 and `w_ready`=1. Any other combination stores nothing.
- R2: A read request is `r_cs_n`=0, `r_rd`=1, `r_en`=1, `r_mbx`=0 on a rising `rclk` edge while `r_valid`=1. Any other combination leaves `r_data` and `r_valid` unchanged.
- R3: `w_ready` goes low right after the write edge that stores the DEPTH-th unread word. Writes attempted while it is low are discarded.
- R4: In standard mode (`fwft`=0), `r_valid` rises after the second rising `rclk` edge that follows the write of a word into an empty FIFO. `r_data` does not change until a qualified read, which loads the oldest word.
- R5: In standard mode, `r_valid` drops right after the read edge that removes the last stored word.
- R6: In fall-through mode (`fwft`=1), with `r_valid` low, a newly written word is placed in `r_data` on the same `rclk` edge that raises `r_valid`. That edge is the third edge after the write.
- R7: In fall-through mode, while `r_valid` is high, `r_data` holds until a qualified read. That read shows the next word, or drops `r_valid` if none is stored.
- R8: Words leave in the order they were written, at full width.
- R9: `rst` is synchronous, active high, and held for at least four rising edges of each clock. It empties the FIFO and sets `w_ready`=1, `w_afull`=0, `r_valid`=0, `r_aempty`=1 and `r_data`=0.
- R10: The offset comes from the value of `ofs_sel` while `rst` is high: 0→8, 1→16, 2→64, 3→256, each limited to DEPTH−4. Changes to `ofs_sel` after reset have no effect.
- R11: `w_afull` is registered on `wclk`. It is high when the free slots, counted after the current edge's write, are at most the offset.
- R12: `r_aempty` is registered on `rclk`. It is high when the stored words, counted after the current edge's read, are at most the offset. In fall-through mode the stored words include a word held in `r_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset for both domains |
| fwft | input | 1 | Read mode: 0 standard, 1 fall-through; change only during reset |
| ofs_sel | input | 2 | Threshold offset select, captured during reset |
| w_cs_n | input | 1 | Write port select, active low |
| w_dir | input | 1 | Write port direction, 1 = write |
| w_en | input | 1 | Write port enable |
| w_mbx | input | 1 | Side-channel select; must be 0 for a FIFO write |
| w_data | input | DW | Word to write |
| w_ready | output | 1 | High when a word can be accepted |
| w_afull | output | 1 | Almost-full threshold flag |
| r_cs_n | input | 1 | Read port select, active low |
| r_rd | input | 1 | Read port direction, 1 = read |
| r_en | input | 1 | Read port enable |
| r_mbx | input | 1 | Side-channel select; must be 0 for a FIFO read |
| r_data | output | DW | Output word register |
| r_valid | output | 1 | Not-empty (standard) or output-ready (fall-through) |
| r_aempty | output | 1 | Almost-empty threshold flag |

## Verification
The bench builds the block with DW=36 and DEPTH=16. The full flag and wrap-around of the pointers are then reached within sixteen writes, and selects 1 to 3 are limited to an offset of 12 while select 0 keeps 8. This exposes both the clipping rule and the select latch. The clocks run at 8 ns and 11 ns with edges that never coincide. The exact second-edge and third-edge timing of `r_valid` can therefore be counted in read-clock edges after a known write edge.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Preset threshold offsets, limited so a flag can still toggle in small FIFOs.
  function automatic int unsigned pick_offset(input logic [1:0] sel,
                                              input int unsigned depth);
    int unsigned v;
    case (sel)
      2'd0:    v = 8;
      2'd1:    v = 16;
      2'd2:    v = 64;
      default: v = 256;
    endcase
    if (v > depth - 4) v = depth - 4;
    return v;
  endfunction

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 36,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 2 ** AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register doubles as the FIFO's read data register.
  always_ff @(posedge rclk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic        wclk,
  input  logic        rst,
  input  logic [1:0]  ofs_sel,
  input  logic        push_ask,
  input  logic [AW:0] r_gray_s,
  output logic [AW:0] w_gray,
  output logic [AW-1:0] waddr,
  output logic        we,
  output logic        w_ready,
  output logic        w_afull
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, used_nxt, free_nxt, ofs_q;
  logic          full;

  // Full when the pointers differ only in the top two Gray bits.
  assign full    = (w_gray == {~r_gray_s[PW-1:PW-2], r_gray_s[PW-3:0]});
  assign w_ready = ~full;
  assign we      = push_ask & ~full;
  assign waddr   = wbin[AW-1:0];

  always_comb begin
    rbin_s   = PW'(dcf_pkg::gray_to_bin(32'(r_gray_s)));
    wbin_nxt = wbin + PW'(we);
    used_nxt = wbin_nxt - rbin_s;
    free_nxt = PW'(DEPTH) - used_nxt;
  end

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin    <= '0;
      w_gray  <= '0;
      w_afull <= 1'b0;
      ofs_q   <= PW'(dcf_pkg::pick_offset(ofs_sel, DEPTH));
    end else begin
      wbin    <= wbin_nxt;
      w_gray  <= PW'(dcf_pkg::bin_to_gray(32'(wbin_nxt)));
      w_afull <= (free_nxt <= ofs_q);
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          fwft,
  input  logic [1:0]    ofs_sel,
  input  logic          rd_ask,
  input  logic [AW:0]   w_gray_s,
  output logic [AW:0]   r_gray,
  output logic [AW-1:0] raddr,
  output logic          take,
  output logic          r_valid,
  output logic          r_aempty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nxt, wbin_s, level_nxt, ofs_q;
  logic          mem_has, ovalid, ovalid_nxt, pop;

  assign mem_has = (w_gray_s != r_gray);
  assign r_valid = fwft ? ovalid : mem_has;
  assign pop     = rd_ask & r_valid;
  assign raddr   = rbin[AW-1:0];

  always_comb begin
    if (fwft) begin
      // Preload whenever the output register is empty or being consumed.
      take       = mem_has & (~ovalid | pop);
      ovalid_nxt = take | (ovalid & ~pop);
    end else begin
      take       = pop;
      ovalid_nxt = 1'b0;
    end
    wbin_s    = PW'(dcf_pkg::gray_to_bin(32'(w_gray_s)));
    rbin_nxt  = rbin + PW'(take);
    level_nxt = wbin_s - rbin_nxt + PW'(ovalid_nxt);
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin     <= '0;
      r_gray   <= '0;
      ovalid   <= 1'b0;
      r_aempty <= 1'b1;
      ofs_q    <= PW'(dcf_pkg::pick_offset(ofs_sel, DEPTH));
    end else begin
      rbin     <= rbin_nxt;
      r_gray   <= PW'(dcf_pkg::bin_to_gray(32'(rbin_nxt)));
      ovalid   <= ovalid_nxt;
      r_aempty <= (level_nxt <= ofs_q);
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DW          = 36,
  parameter int DEPTH       = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          fwft,
  input  logic [1:0]    ofs_sel,
  input  logic          w_cs_n,
  input  logic          w_dir,
  input  logic          w_en,
  input  logic          w_mbx,
  input  logic [DW-1:0] w_data,
  output logic          w_ready,
  output logic          w_afull,
  input  logic          r_cs_n,
  input  logic          r_rd,
  input  logic          r_en,
  input  logic          r_mbx,
  output logic [DW-1:0] r_data,
  output logic          r_valid,
  output logic          r_aempty
);
  // DEPTH must be a power of two, at least 8.
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          push_ask, rd_ask, we, take;
  logic [PW-1:0] w_ptr_gray, r_ptr_gray, w_gray_s, r_gray_s;
  logic [AW-1:0] waddr, raddr;

  assign push_ask = ~w_cs_n & w_dir & w_en & ~w_mbx;
  assign rd_ask   = ~r_cs_n & r_rd & r_en & ~r_mbx;

  dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .wclk(wclk), .rst(rst), .ofs_sel(ofs_sel), .push_ask(push_ask),
    .r_gray_s(r_gray_s), .w_gray(w_ptr_gray), .waddr(waddr), .we(we),
    .w_ready(w_ready), .w_afull(w_afull)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(rst), .d(r_ptr_gray), .q(r_gray_s)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rst), .d(w_ptr_gray), .q(w_gray_s)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .rclk(rclk), .rst(rst), .fwft(fwft), .ofs_sel(ofs_sel), .rd_ask(rd_ask),
    .w_gray_s(w_gray_s), .r_gray(r_ptr_gray), .raddr(raddr), .take(take),
    .r_valid(r_valid), .r_aempty(r_aempty)
  );

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(w_data),
    .rclk(rclk), .rst(rst), .re(take), .raddr(raddr), .rdata(r_data)
  );
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int DW = 36,
  parameter int PW = 10
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          fwft,
  input logic          w_ready,
  input logic [PW-1:0] w_gray,
  input logic [PW-1:0] r_gray,
  input logic          r_valid,
  input logic [DW-1:0] r_data,
  input logic          rd_ask
);
  // A full FIFO never advances its write pointer.
  assert_full_blocks_R3: assert property (@(posedge wclk) disable iff (rst)
    !w_ready |=> $stable(w_gray));

  // Pointers crossing domains change one Gray bit per step (keeps order, R8).
  assert_wgray_step_R8: assert property (@(posedge wclk) disable iff (rst)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  assert_rgray_step_R8: assert property (@(posedge rclk) disable iff (rst)
    $countones(r_gray ^ $past(r_gray)) <= 1);

  // Standard mode: an empty FIFO never advances its read pointer.
  assert_no_underflow_R2: assert property (@(posedge rclk) disable iff (rst)
    (!fwft && !r_valid) |=> $stable(r_gray));

  // Standard mode: the output word changes only through a granted read.
  assert_std_hold_R4: assert property (@(posedge rclk) disable iff (rst)
    (!fwft && !(rd_ask && r_valid)) |=> $stable(r_data));

  // Fall-through mode: a shown word stays until it is consumed.
  assert_fwft_hold_R7: assert property (@(posedge rclk) disable iff (rst)
    (fwft && r_valid && !rd_ask) |=> (r_valid && $stable(r_data)));
endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .fwft(fwft), .w_ready(w_ready),
  .w_gray(w_ptr_gray), .r_gray(r_ptr_gray), .r_valid(r_valid),
  .r_data(r_data), .rd_ask(rd_ask)
);

// File: tb/dcf_fifo_test.sv
module dcf_fifo_test;
  localparam int DW    = 36;
  localparam int DEPTH = 16;
  localparam int NV    = 8;
  localparam logic [DW-1:0] VEC [NV] = '{
    36'h0_0000_0001, 36'hF_FFFF_FFFF, 36'hA_5A5A_5A5A, 36'h5_A5A5_A5A5,
    36'h8_0000_0000, 36'h0_1234_5678, 36'h7_FFFF_FFFE, 36'h0_0000_0000
  };

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1, fwft = 1'b0;
  logic [1:0] ofs_sel = 2'd0;
  logic w_cs_n = 1'b1, w_dir = 1'b0, w_en = 1'b0, w_mbx = 1'b0;
  logic [DW-1:0] w_data = '0;
  logic r_cs_n = 1'b1, r_rd = 1'b0, r_en = 1'b0, r_mbx = 1'b0;
  logic w_ready, w_afull, r_valid, r_aempty;
  logic [DW-1:0] r_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4   wclk = ~wclk;   // 125 MHz
  always #5.5 rclk = ~rclk;   // unrelated read clock, edges never coincide

  dcf_fifo #(.DW(DW), .DEPTH(DEPTH)) uut (
    .wclk(wclk), .rclk(rclk), .rst(rst), .fwft(fwft), .ofs_sel(ofs_sel),
    .w_cs_n(w_cs_n), .w_dir(w_dir), .w_en(w_en), .w_mbx(w_mbx),
    .w_data(w_data), .w_ready(w_ready), .w_afull(w_afull),
    .r_cs_n(r_cs_n), .r_rd(r_rd), .r_en(r_en), .r_mbx(r_mbx),
    .r_data(r_data), .r_valid(r_valid), .r_aempty(r_aempty)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic mode);
    @(negedge wclk);
    rst = 1'b1; ofs_sel = sel; fwft = mode;
    repeat (8) @(negedge wclk);
    rst = 1'b0;
    repeat (3) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  task automatic wr_try(input logic cs_n, input logic dir, input logic en,
                        input logic mbx, input logic [DW-1:0] d);
    @(negedge wclk);
    w_cs_n = cs_n; w_dir = dir; w_en = en; w_mbx = mbx; w_data = d;
    @(negedge wclk);
    w_cs_n = 1'b1; w_en = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    wr_try(1'b0, 1'b1, 1'b1, 1'b0, d);
  endtask

  task automatic rd_try(input logic cs_n, input logic rd, input logic en,
                        input logic mbx);
    @(negedge rclk);
    r_cs_n = cs_n; r_rd = rd; r_en = en; r_mbx = mbx;
    @(negedge rclk);
    r_cs_n = 1'b1; r_en = 1'b0;
  endtask

  task automatic pop();
    rd_try(1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  // Write one word and return right after the write edge (NBA release of enable).
  task automatic push_at_edge(input logic [DW-1:0] d);
    @(negedge wclk);
    w_cs_n = 1'b0; w_dir = 1'b1; w_en = 1'b1; w_mbx = 1'b0; w_data = d;
    @(posedge wclk);
    w_en <= 1'b0;
    w_cs_n <= 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state
    do_reset(2'd0, 1'b0);
    check("R9 w_ready", w_ready, 1);
    check("R9 w_afull", w_afull, 0);
    check("R9 r_valid", r_valid, 0);
    check("R9 r_aempty", r_aempty, 1);
    check("R9 r_data", r_data, 0);

    // R1: each missing qualifier blocks the write
    wr_try(1'b1, 1'b1, 1'b1, 1'b0, 36'h111);
    wr_try(1'b0, 1'b0, 1'b1, 1'b0, 36'h222);
    wr_try(1'b0, 1'b1, 1'b0, 1'b0, 36'h333);
    wr_try(1'b0, 1'b1, 1'b1, 1'b1, 36'h444);
    repeat (8) @(negedge rclk);
    check("R1 nothing stored", r_valid, 0);

    // R4: not-empty rises after the second read-clock edge
    push_at_edge(36'hABC_DEF01);
    @(posedge rclk); @(negedge rclk);
    check("R4 r_valid after 1st edge", r_valid, 0);
    @(posedge rclk); @(negedge rclk);
    check("R4 r_valid after 2nd edge", r_valid, 1);
    check("R4 r_data not preloaded", r_data, 0);

    // R2: each missing qualifier blocks the read
    rd_try(1'b1, 1'b1, 1'b1, 1'b0);
    rd_try(1'b0, 1'b0, 1'b1, 1'b0);
    rd_try(1'b0, 1'b1, 1'b0, 1'b0);
    rd_try(1'b0, 1'b1, 1'b1, 1'b1);
    check("R2 r_valid kept", r_valid, 1);
    check("R2 r_data kept", r_data, 0);
    pop();
    check("R4 read loads word", r_data, 36'hABC_DEF01);
    check("R5 empty after last read", r_valid, 0);

    // R8: vector table, written then read back in order
    for (int i = 0; i < NV; i++) push(VEC[i]);
    repeat (6) @(negedge rclk);
    for (int i = 0; i < NV; i++) begin
      pop();
      check($sformatf("R8 order word %0d", i), r_data, VEC[i]);
    end
    check("R5 empty after table", r_valid, 0);

    // R10/R11: select 0 gives offset 8 -> afull once 8 words are held
    repeat (4) @(negedge wclk);
    for (int k = 1; k <= 9; k++) begin
      push(36'h100 + 36'(k));
      if (k == 7) check("R11 afull at 7 words", w_afull, 0);
      if (k == 8) check("R10 R11 afull at 8 words", w_afull, 1);
    end
    repeat (8) @(negedge rclk);
    check("R12 aempty at 9 words", r_aempty, 0);
    pop();
    check("R12 aempty at 8 words", r_aempty, 1);
    check("R8 first of batch", r_data, 36'h101);
    for (int k = 2; k <= 9; k++) pop();
    check("R8 last of batch", r_data, 36'h109);

    // R10: select 1 clipped to 12 for DEPTH 16; later select change ignored
    do_reset(2'd1, 1'b0);
    ofs_sel = 2'd0;
    for (int k = 1; k <= DEPTH; k++) begin
      push(36'h200 + 36'(k));
      if (k == 3) check("R10 afull at 3 words (offset 12)", w_afull, 0);
      if (k == 4) check("R10 afull at 4 words (offset 12)", w_afull, 1);
      if (k == DEPTH - 1) check("R3 ready before full", w_ready, 1);
    end
    check("R3 not ready when full", w_ready, 0);
    push(36'hBAD);
    repeat (8) @(negedge rclk);
    for (int k = 1; k <= DEPTH; k++) begin
      pop();
      check($sformatf("R8 full-fill word %0d", k), r_data, 36'h200 + 36'(k));
    end
    check("R3 write while full discarded", r_valid, 0);

    // R6/R7: fall-through mode
    do_reset(2'd0, 1'b1);
    check("R9 fwft r_valid", r_valid, 0);
    push_at_edge(36'hB0B);
    @(posedge rclk); @(negedge rclk);
    @(posedge rclk); @(negedge rclk);
    check("R6 not ready after 2nd edge", r_valid, 0);
    @(posedge rclk); @(negedge rclk);
    check("R6 ready after 3rd edge", r_valid, 1);
    check("R6 word preloaded", r_data, 36'hB0B);
    push(36'hC0C);
    push(36'hD0D);
    repeat (8) @(negedge rclk);
    check("R7 head held without read", r_data, 36'hB0B);
    rd_try(1'b0, 1'b1, 1'b1, 1'b1);
    check("R7 unqualified read ignored", r_data, 36'hB0B);
    pop();
    check("R7 next word shown", r_data, 36'hC0C);
    pop();
    check("R7 last word shown", r_data, 36'hD0D);
    check("R7 still ready", r_valid, 1);
    pop();
    check("R7 ready drops when drained", r_valid, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule